// File: doc/BRIEF.md
# SCL Clock Generator with Affine Divider

This block produces the serial clock timing for a two-wire bus master from the system clock. A 7-bit divider code and a speed select set the length of one SCL period as an affine function of the code. The slope and the offset both depend on the selected speed, and each speed has its own minimum code. The block does not toggle a clock net. It raises a drive-low request for the open-drain pad and emits one-cycle strobes at each falling and rising SCL edge, which a bit-level engine uses to time data changes and sampling.

Each period begins with the low phase, which takes the larger half of the period, followed by the high phase. In the high phase the block watches the sampled bus line. While a slave holds the line low, the count stops, so slave clock stretching extends the high phase by exactly the stretched cycles. When the block is disabled or no transfer is requested, it releases the line and stays quiet. A new code or speed written during a transfer is applied only from the next period start.

Top module: `scl_clkgen`

## Requirements
- R1: While `en` or `run` is low at a clock edge, the next cycle has `scl_low_req`, `scl_rise` and `scl_fall` all at 0. This holds whether the block is idle or partway through a period.
- R2: With `std_mode`=1 and a code C of 3 or more, one SCL period (low cycles plus unstretched high cycles) is 3·C+11 system clock cycles.
- R3: With `std_mode`=0 and a code C of 2 or more, one SCL period is 2·C+9 system clock cycles.
- R4: A code below the minimum for the selected speed (3 when `std_mode`=1, 2 when `std_mode`=0) produces the same period as the minimum code.
- R5: For a period of P cycles, `scl_low_req` stays at 1 for ceil(P/2) consecutive cycles, and then stays at 0 for floor(P/2) cycles when there is no stretching.
- R6: `scl_fall` is 1 for exactly the first cycle in which `scl_low_req` is 1. `scl_rise` is 1 for exactly the first cycle in which it returns to 0 inside a transfer. The two strobes are never 1 together.
- R7: During the high phase, each clock edge that samples `scl_in`=0 stops the count. The high phase therefore lasts floor(P/2) cycles plus the number of such edges.
- R8: A change of `div_code` or `std_mode` during a transfer leaves the current period unchanged. The new timing applies from the next falling strobe.
- R9: In the first cycle after an edge that sees `en` and `run` both at 1 while idle, `scl_low_req` and `scl_fall` are both 1, and a full low phase follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Interface enable |
| run | input | 1 | Transfer request; SCL toggles while this and `en` are high |
| div_code | input | 7 | Divider code |
| std_mode | input | 1 | 1 selects standard speed, 0 selects fast speed |
| scl_in | input | 1 | Synchronized level of the SCL line |
| scl_low_req | output | 1 | 1 asks the pad to pull SCL low |
| scl_rise | output | 1 | One-cycle strobe at the start of each high phase |
| scl_fall | output | 1 | One-cycle strobe at the start of each low phase |

## Verification
The bench sweeps every code in both speeds and checks the low and high phase lengths separately. An off-by-one in either reload, a swapped ceiling and floor, or a wrong slope or offset therefore shows up as a phase that is one cycle too long or too short. The codes below each minimum are covered as well, so a missing clamp would produce a short period. A stretch of five cycles must add exactly five cycles: a counter that kept running would give the unstretched length, and one that restarted would give a longer one. A mid-transfer reconfiguration must leave the current period alone, and a disable in the middle of a phase must release the line on the very next cycle.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } scl_phase_e;

  // Raise a code that is below the speed's minimum up to that minimum.
  function automatic int unsigned clamp_code(input int unsigned code,
                                             input int unsigned floor_v);
    return (code < floor_v) ? floor_v : code;
  endfunction

  // Period length in system clock cycles: slope times clamped code, plus offset.
  function automatic int unsigned period_of(input int unsigned code,
                                            input int unsigned mul,
                                            input int unsigned add,
                                            input int unsigned floor_v);
    return mul * clamp_code(code, floor_v) + add;
  endfunction

  // The low phase takes the larger half of an odd period.
  function automatic int unsigned low_part(input int unsigned p);
    return (p + 1) >> 1;
  endfunction

  function automatic int unsigned high_part(input int unsigned p);
    return p >> 1;
  endfunction

endpackage

// File: rtl/scl_timing_calc.sv
module scl_timing_calc
  import scl_div_pkg::*;
#(
  parameter int unsigned CODE_W   = 7,
  parameter int unsigned PER_W    = 10,
  parameter int unsigned STD_MUL  = 3,
  parameter int unsigned STD_ADD  = 11,
  parameter int unsigned STD_MIN  = 3,
  parameter int unsigned FAST_MUL = 2,
  parameter int unsigned FAST_ADD = 9,
  parameter int unsigned FAST_MIN = 2
) (
  input  logic [CODE_W-1:0] code,
  input  logic              std_sel,
  output logic [PER_W-1:0]  low_len,
  output logic [PER_W-1:0]  high_len
);

  logic [31:0] code_w;
  logic [31:0] period_w;

  assign code_w = {{(32-CODE_W){1'b0}}, code};

  always_comb begin
    if (std_sel) period_w = period_of(code_w, STD_MUL, STD_ADD, STD_MIN);
    else         period_w = period_of(code_w, FAST_MUL, FAST_ADD, FAST_MIN);
    low_len  = PER_W'(low_part(period_w));
    high_len = PER_W'(high_part(period_w));
  end

endmodule

// File: rtl/scl_cfg_hold.sv
module scl_cfg_hold #(
  parameter int unsigned W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end

  // R8: the held high-phase length changes only at a period start.
  p_hold_between_loads_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q));

endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
  import scl_div_pkg::*;
#(
  parameter int unsigned PER_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             scl_in,
  input  logic [PER_W-1:0] new_low,
  input  logic [PER_W-1:0] cur_high,
  output logic             load_cfg,
  output logic             low_req,
  output logic             rise_stb,
  output logic             fall_stb
);

  scl_phase_e       ph_q, ph_n;
  logic [PER_W-1:0] cnt_q, cnt_n;
  logic             cnt_zero;
  logic             stretching;

  assign cnt_zero   = (cnt_q == '0);
  assign stretching = active && (ph_q == PH_HIGH) && !scl_in;

  always_comb begin
    ph_n     = ph_q;
    cnt_n    = cnt_q;
    load_cfg = 1'b0;
    if (!active) begin
      ph_n  = PH_IDLE;
      cnt_n = '0;
    end else begin
      unique case (ph_q)
        PH_IDLE: begin
          ph_n     = PH_LOW;
          cnt_n    = new_low - PER_W'(1);
          load_cfg = 1'b1;
        end
        PH_LOW: begin
          if (cnt_zero) begin
            ph_n  = PH_HIGH;
            cnt_n = cur_high - PER_W'(1);
          end else begin
            cnt_n = cnt_q - PER_W'(1);
          end
        end
        PH_HIGH: begin
          if (scl_in) begin
            if (cnt_zero) begin
              ph_n     = PH_LOW;
              cnt_n    = new_low - PER_W'(1);
              load_cfg = 1'b1;
            end else begin
              cnt_n = cnt_q - PER_W'(1);
            end
          end
        end
        default: begin
          ph_n  = PH_IDLE;
          cnt_n = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q     <= PH_IDLE;
      cnt_q    <= '0;
      rise_stb <= 1'b0;
      fall_stb <= 1'b0;
    end else begin
      ph_q     <= ph_n;
      cnt_q    <= cnt_n;
      fall_stb <= (ph_n == PH_LOW)  && (ph_q != PH_LOW);
      rise_stb <= (ph_n == PH_HIGH) && (ph_q != PH_HIGH);
    end
  end

  assign low_req = (ph_q == PH_LOW);

  // R1: a dropped request silences the line and both strobes on the next cycle.
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (ph_q == PH_IDLE) && !low_req && !rise_stb && !fall_stb);

  // R6: the edge strobes are never 1 in the same cycle.
  p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_stb && fall_stb));

  // R6: a falling strobe comes only together with a low request.
  p_fall_with_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fall_stb |-> low_req);

  // R7: a slave holding the line low freezes the count.
  p_stretch_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stretching |=> ($stable(cnt_q) || (ph_q == PH_IDLE)));

  // R9: a request seen while idle starts a low phase with its strobe.
  p_start_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (active && ph_q == PH_IDLE) |=> (low_req && fall_stb));

endmodule

// File: rtl/scl_clkgen.sv
module scl_clkgen #(
  parameter int unsigned CODE_W   = 7,
  parameter int unsigned STD_MUL  = 3,
  parameter int unsigned STD_ADD  = 11,
  parameter int unsigned STD_MIN  = 3,
  parameter int unsigned FAST_MUL = 2,
  parameter int unsigned FAST_ADD = 9,
  parameter int unsigned FAST_MIN = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              run,
  input  logic [CODE_W-1:0] div_code,
  input  logic              std_mode,
  input  logic              scl_in,
  output logic              scl_low_req,
  output logic              scl_rise,
  output logic              scl_fall
);

  localparam int unsigned PER_W     = CODE_W + 3;
  localparam int unsigned STD_PMIN  = STD_MUL * STD_MIN + STD_ADD;
  localparam int unsigned FAST_PMIN = FAST_MUL * FAST_MIN + FAST_ADD;

  logic             active;
  logic             period_start;
  logic [PER_W-1:0] calc_low;
  logic [PER_W-1:0] calc_high;
  logic [PER_W-1:0] held_high;

  assign active = en && run;

  scl_timing_calc #(
    .CODE_W(CODE_W), .PER_W(PER_W),
    .STD_MUL(STD_MUL), .STD_ADD(STD_ADD), .STD_MIN(STD_MIN),
    .FAST_MUL(FAST_MUL), .FAST_ADD(FAST_ADD), .FAST_MIN(FAST_MIN)
  ) u_calc (
    .code    (div_code),
    .std_sel (std_mode),
    .low_len (calc_low),
    .high_len(calc_high)
  );

  scl_cfg_hold #(.W(PER_W)) u_hold (
    .clk  (clk),
    .rst_n(rst_n),
    .load (period_start),
    .d    (calc_high),
    .q    (held_high)
  );

  scl_phase_fsm #(.PER_W(PER_W)) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .active  (active),
    .scl_in  (scl_in),
    .new_low (calc_low),
    .cur_high(held_high),
    .load_cfg(period_start),
    .low_req (scl_low_req),
    .rise_stb(scl_rise),
    .fall_stb(scl_fall)
  );

  // R4: the period taken from the calculator never falls below the speed's floor.
  p_min_period_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(calc_low) + 32'(calc_high)) >= (std_mode ? STD_PMIN : FAST_PMIN));

endmodule

// File: tb/sim_scl_clkgen.sv
module sim_scl_clkgen;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       run = 1'b0;
  logic [6:0] div_code = 7'd0;
  logic       std_mode = 1'b0;
  logic       hold = 1'b0;
  logic       scl_in;
  logic       scl_low_req, scl_rise, scl_fall;

  int n_checks = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  // Wired-AND bus: the master pull-down or a stretching slave makes the line low.
  assign scl_in = !scl_low_req && !hold;

  scl_clkgen u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .run(run), .div_code(div_code),
    .std_mode(std_mode), .scl_in(scl_in), .scl_low_req(scl_low_req),
    .scl_rise(scl_rise), .scl_fall(scl_fall)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_period(input int code, input bit std);
    int base;
    base = std ? ((code < 3) ? 3 : code) : ((code < 2) ? 2 : code);
    return std ? (base + base + base + 11) : (base + base + 9);
  endfunction

  // Entered at a negedge in a cycle with scl_fall high; returns at the next fall cycle.
  task automatic run_period(output int lo, output int hi, output bit rise_ok);
    lo = 0; hi = 0;
    while (scl_low_req) begin
      lo++;
      @(negedge clk);
    end
    rise_ok = scl_rise && !scl_fall;
    while (!scl_low_req) begin
      hi++;
      @(negedge clk);
    end
  endtask

  initial begin
    int lo, hi, p;
    bit rok;
    repeat (3) @(negedge clk);
    check(!scl_low_req && !scl_rise && !scl_fall, "R1", "reset outputs", scl_low_req, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: enable without run, then run without enable, keeps the line released.
    en = 1'b1;
    repeat (20) begin
      @(negedge clk);
      check(!scl_low_req && !scl_rise && !scl_fall, "R1", "en only", scl_low_req, 0);
    end
    en = 1'b0; run = 1'b1;
    repeat (20) begin
      @(negedge clk);
      check(!scl_low_req && !scl_rise && !scl_fall, "R1", "run only", scl_low_req, 0);
    end
    run = 1'b0;
    @(negedge clk);

    // R2 R3 R4 R5 R6 R9: sweep of every code in both speeds.
    for (int m = 0; m < 2; m++) begin
      for (int c = 0; c < 128; c++) begin
        div_code = 7'(c); std_mode = m[0];
        en = 1'b1; run = 1'b1;
        @(negedge clk);
        check(scl_low_req && scl_fall && !scl_rise, "R9", "start cycle", scl_fall, 1);
        p = exp_period(c, m[0]);
        run_period(lo, hi, rok);
        if ((m == 1 && c < 3) || (m == 0 && c < 2))
          check(lo + hi == p, "R4", "clamped period", lo + hi, p);
        else if (m == 1)
          check(lo + hi == p, "R2", "standard period", lo + hi, p);
        else
          check(lo + hi == p, "R3", "fast period", lo + hi, p);
        check(lo == (p + 1) / 2, "R5", "low length", lo, (p + 1) / 2);
        check(rok, "R6", "rise strobe", rok, 1);
        check(scl_fall && scl_low_req && !scl_rise, "R6", "fall strobe", scl_fall, 1);
        run = 1'b0;
        @(negedge clk);
      end
    end

    // R7: standard code 3 gives 10 low and 10 high; hold the line for 5 edges.
    div_code = 7'd3; std_mode = 1'b1; run = 1'b1;
    @(negedge clk);
    lo = 0;
    while (scl_low_req) begin lo++; @(negedge clk); end
    check(lo == 10, "R5", "low before stretch", lo, 10);
    hi = 0;
    hold = 1'b1;
    while (!scl_low_req) begin
      hi++;
      if (hi == 6) hold = 1'b0;
      @(negedge clk);
    end
    hold = 1'b0;
    check(hi == 15, "R7", "stretched high", hi, 15);
    run = 1'b0;
    @(negedge clk);

    // R8: fast code 2 (7/6), switched to standard code 5 (13/13) inside the low phase.
    div_code = 7'd2; std_mode = 1'b0; run = 1'b1;
    @(negedge clk);
    @(negedge clk);
    div_code = 7'd5; std_mode = 1'b1;
    lo = 1;
    while (scl_low_req) begin lo++; @(negedge clk); end
    hi = 0;
    while (!scl_low_req) begin hi++; @(negedge clk); end
    check(lo == 7 && hi == 6, "R8", "old period kept", lo * 100 + hi, 706);
    run_period(lo, hi, rok);
    check(lo == 13 && hi == 13, "R8", "new period applied", lo * 100 + hi, 1313);

    // R1: dropping enable in the middle of a low phase releases at once.
    repeat (4) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    check(!scl_low_req && !scl_rise && !scl_fall, "R1", "disable mid low", scl_low_req, 0);
    repeat (10) begin
      @(negedge clk);
      check(!scl_low_req && !scl_fall, "R1", "stays idle", scl_low_req, 0);
    end

    // R9: re-enable restarts with a full low phase.
    en = 1'b1;
    @(negedge clk);
    check(scl_fall && scl_low_req, "R9", "restart strobe", scl_fall, 1);
    run_period(lo, hi, rok);
    check(lo == 13, "R9", "restart low length", lo, 13);
    run = 1'b0; en = 1'b0;
    @(negedge clk);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule